// File: doc/BRIEF.md
# Stream FIFO level interrupt controller

This block turns the fill-level status of a group of streaming links into two interrupt requests, one for the receive direction and one for the transmit direction. Each link has a receive FIFO and a transmit FIFO, and each FIFO reports its status to the block. For every link, a configuration word enables each direction and picks its trigger condition. For receive, the choice is "has data" or "at least half full". For transmit, the choice is "has room" or "below half full".

A request becomes pending only when the selected condition changes from false to true, so a FIFO that stays in the condition does not raise the request again. Pending requests have no dedicated clear register. Normal bus traffic acknowledges them instead: a data read clears receive requests, a data write clears transmit requests, and a control write clears both. Turning the module off clears both and keeps them clear. The FIFOs, the bus decoding and the data paths sit outside the block.

Top module: `stream_fifo_irq`

## Requirements
- R1: After reset, `irq_rx` and `irq_tx` are 0.
- R2: With link i's RX enable (`irq_cfg` bit i) set and its RX mode (`irq_cfg` bit 8+i) at 0, `rx_empty[i]` going from 1 to 0 raises `irq_rx` at the clock edge that samples the change. `irq_rx` then stays high until a clearing access.
- R3: With RX mode 1, a link raises `irq_rx` when `rx_half[i]` goes from 0 to 1. A change of `rx_empty` alone raises nothing.
- R4: With link i's TX enable (bit 16+i) set and its TX mode (bit 24+i) at 0, `tx_full[i]` going from 1 to 0 raises `irq_tx` at the edge that samples the change. `tx_full` rising raises nothing.
- R5: With TX mode 1, a link raises `irq_tx` when `tx_half[i]` goes from 1 to 0. A change of `tx_full` alone raises nothing.
- R6: Triggering is on the transition only. After a clear, a condition that stays true does not raise the request again.
- R7: A transition on a link whose enable bit for that direction is 0 raises nothing.
- R8: A cycle with `data_rd` or `ctrl_wr` high clears `irq_rx` at the following edge. `data_wr` leaves `irq_rx` unchanged.
- R9: A cycle with `data_wr` or `ctrl_wr` high clears `irq_tx` at the following edge. `data_rd` leaves `irq_tx` unchanged.
- R10: While `mod_en` is 0, both requests are cleared at each edge and no transition makes either one pending.
- R11: If a new trigger and a clearing access occur in the same cycle, the request is pending after that edge.
- R12: When RX_DEPTH is 1, every RX mode bit behaves as 1. When TX_DEPTH is 1, every TX mode bit behaves as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mod_en | input | 1 | Module enable; 0 clears and blocks requests |
| irq_cfg | input | 32 | Bits 7:0 RX enable, 15:8 RX mode, 23:16 TX enable, 31:24 TX mode; bit i of each field is link i |
| rx_empty | input | NUM_LINKS | RX FIFO empty, per link |
| rx_half | input | NUM_LINKS | RX FIFO at least half full, per link |
| tx_full | input | NUM_LINKS | TX FIFO full, per link |
| tx_half | input | NUM_LINKS | TX FIFO at least half full, per link |
| data_rd | input | 1 | Strobe: read of any link data register |
| data_wr | input | 1 | Strobe: write of any link data register |
| ctrl_wr | input | 1 | Strobe: write of the control register |
| irq_rx | output | 1 | Registered RX interrupt request |
| irq_tx | output | 1 | Registered TX interrupt request |

## Verification
The bench builds two instances. The main instance has four links and FIFO depths of 8, so both mode settings, the per-link enables and all three clearing sources can be exercised on different links. The second instance has two links and both FIFO depths set to 1. With its mode bits written as 0, it shows that only the half-level conditions trigger. Collisions between a trigger and a clearing access are driven on the main instance.

// File: rtl/stream_fifo_irq.sv
module stream_fifo_irq #(
  parameter int NUM_LINKS = 4,
  parameter int RX_DEPTH  = 8,
  parameter int TX_DEPTH  = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 mod_en,
  input  logic [31:0]          irq_cfg,
  input  logic [NUM_LINKS-1:0] rx_empty,
  input  logic [NUM_LINKS-1:0] rx_half,
  input  logic [NUM_LINKS-1:0] tx_full,
  input  logic [NUM_LINKS-1:0] tx_half,
  input  logic                 data_rd,
  input  logic                 data_wr,
  input  logic                 ctrl_wr,
  output logic                 irq_rx,
  output logic                 irq_tx
);
  localparam int FW = 8;
  localparam bit RX_FORCE_HALF = (RX_DEPTH == 1);
  localparam bit TX_FORCE_HALF = (TX_DEPTH == 1);

  logic [NUM_LINKS-1:0] rx_en, rx_mode, tx_en, tx_mode;
  logic [NUM_LINKS-1:0] rx_sel, tx_sel, rx_cond_q, tx_cond_q;
  logic [NUM_LINKS-1:0] set_rx, set_tx, rx_pend, tx_pend, rx_pend_nxt, tx_pend_nxt;
  logic clr_rx, clr_tx, set_rx_any, set_tx_any;
  logic unused_cfg;

  assign rx_en   = irq_cfg[0*FW +: NUM_LINKS];
  assign rx_mode = irq_cfg[1*FW +: NUM_LINKS];
  assign tx_en   = irq_cfg[2*FW +: NUM_LINKS];
  assign tx_mode = irq_cfg[3*FW +: NUM_LINKS];
  assign unused_cfg = ^irq_cfg;

  for (genvar i = 0; i < NUM_LINKS; i++) begin : g_link
    assign rx_sel[i] = (RX_FORCE_HALF || rx_mode[i]) ? rx_half[i] : ~rx_empty[i];
    assign tx_sel[i] = (TX_FORCE_HALF || tx_mode[i]) ? ~tx_half[i] : ~tx_full[i];
  end

  assign set_rx = {NUM_LINKS{mod_en}} & rx_en & rx_sel & ~rx_cond_q;
  assign set_tx = {NUM_LINKS{mod_en}} & tx_en & tx_sel & ~tx_cond_q;
  assign set_rx_any = |set_rx;
  assign set_tx_any = |set_tx;

  assign clr_rx = data_rd | ctrl_wr | ~mod_en;
  assign clr_tx = data_wr | ctrl_wr | ~mod_en;

  assign rx_pend_nxt = set_rx | (rx_pend & {NUM_LINKS{~clr_rx}});
  assign tx_pend_nxt = set_tx | (tx_pend & {NUM_LINKS{~clr_tx}});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_cond_q <= '0;
      tx_cond_q <= '0;
      rx_pend   <= '0;
      tx_pend   <= '0;
      irq_rx    <= 1'b0;
      irq_tx    <= 1'b0;
    end else begin
      rx_cond_q <= rx_sel;
      tx_cond_q <= tx_sel;
      rx_pend   <= rx_pend_nxt;
      tx_pend   <= tx_pend_nxt;
      irq_rx    <= |rx_pend_nxt;
      irq_tx    <= |tx_pend_nxt;
    end
  end
endmodule

// File: rtl/stream_fifo_irq_chk.sv
module stream_fifo_irq_chk (
  input logic clk,
  input logic rst_n,
  input logic mod_en,
  input logic data_rd,
  input logic data_wr,
  input logic ctrl_wr,
  input logic set_rx_any,
  input logic set_tx_any,
  input logic irq_rx,
  input logic irq_tx
);
  a_r10_off_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !mod_en |=> (!irq_rx && !irq_tx));

  a_r8_rx_ack: assert property (@(posedge clk) disable iff (!rst_n)
    ((data_rd || ctrl_wr) && !set_rx_any) |=> !irq_rx);

  a_r9_tx_ack: assert property (@(posedge clk) disable iff (!rst_n)
    ((data_wr || ctrl_wr) && !set_tx_any) |=> !irq_tx);

  a_r11_set_wins_rx: assert property (@(posedge clk) disable iff (!rst_n)
    set_rx_any |=> irq_rx);

  a_r11_set_wins_tx: assert property (@(posedge clk) disable iff (!rst_n)
    set_tx_any |=> irq_tx);

  a_r2_rx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_rx && mod_en && !data_rd && !ctrl_wr) |=> irq_rx);

  a_r6_rx_rise_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_rx) |-> $past(set_rx_any));

  a_r6_tx_rise_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_tx) |-> $past(set_tx_any));
endmodule

bind stream_fifo_irq stream_fifo_irq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mod_en(mod_en),
  .data_rd(data_rd), .data_wr(data_wr), .ctrl_wr(ctrl_wr),
  .set_rx_any(set_rx_any), .set_tx_any(set_tx_any),
  .irq_rx(irq_rx), .irq_tx(irq_tx)
);

// File: tb/test_stream_fifo_irq.sv
module test_stream_fifo_irq;
  localparam int N = 4;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mod_en = 1'b0;
  logic [31:0] cfg = '0;
  logic [N-1:0] rx_empty = '1, rx_half = '0, tx_full = '1, tx_half = '1;
  logic data_rd = 1'b0, data_wr = 1'b0, ctrl_wr = 1'b0;
  logic irq_rx, irq_tx;

  logic d_en = 1'b0;
  logic [31:0] d_cfg = '0;
  logic [1:0] d_rx_empty = '1, d_rx_half = '0, d_tx_full = '1, d_tx_half = '1;
  logic d_irq_rx, d_irq_tx;

  int checks = 0;
  int fails = 0;

  always #10 clk = ~clk;

  stream_fifo_irq #(.NUM_LINKS(N), .RX_DEPTH(8), .TX_DEPTH(8)) i_stream_fifo_irq (
    .clk(clk), .rst_n(rst_n), .mod_en(mod_en), .irq_cfg(cfg),
    .rx_empty(rx_empty), .rx_half(rx_half), .tx_full(tx_full), .tx_half(tx_half),
    .data_rd(data_rd), .data_wr(data_wr), .ctrl_wr(ctrl_wr),
    .irq_rx(irq_rx), .irq_tx(irq_tx));

  stream_fifo_irq #(.NUM_LINKS(2), .RX_DEPTH(1), .TX_DEPTH(1)) i_stream_fifo_irq_d1 (
    .clk(clk), .rst_n(rst_n), .mod_en(d_en), .irq_cfg(d_cfg),
    .rx_empty(d_rx_empty), .rx_half(d_rx_half), .tx_full(d_tx_full), .tx_half(d_tx_half),
    .data_rd(1'b0), .data_wr(1'b0), .ctrl_wr(1'b0),
    .irq_rx(d_irq_rx), .irq_tx(d_irq_tx));

  task automatic check(input logic act, input logic exp, input string req);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic pulse(input int which);
    if (which == 0) data_rd = 1'b1;
    if (which == 1) data_wr = 1'b1;
    if (which == 2) ctrl_wr = 1'b1;
    tick();
    data_rd = 1'b0; data_wr = 1'b0; ctrl_wr = 1'b0;
  endtask

  task automatic t_reset();
    check(irq_rx, 1'b0, "R1 irq_rx");
    check(irq_tx, 1'b0, "R1 irq_tx");
  endtask

  task automatic t_rx_mode0();
    cfg = 32'h0000_0002;
    rx_empty[1] = 1'b0; tick();
    check(irq_rx, 1'b1, "R2 rx not-empty raises");
    tick();
    check(irq_rx, 1'b1, "R2 rx held");
    pulse(1);
    check(irq_rx, 1'b1, "R8 data_wr keeps rx");
    pulse(0);
    check(irq_rx, 1'b0, "R8 data_rd clears rx");
    tick();
    check(irq_rx, 1'b0, "R6 no retrigger while true");
    rx_empty[1] = 1'b1; tick();
  endtask

  task automatic t_rx_mode1();
    cfg = 32'h0000_0404;
    rx_empty[2] = 1'b0; tick();
    check(irq_rx, 1'b0, "R3 not-empty ignored in mode 1");
    rx_half[2] = 1'b1; tick();
    check(irq_rx, 1'b1, "R3 half raises");
    pulse(2);
    check(irq_rx, 1'b0, "R8 ctrl_wr clears rx");
    rx_half[2] = 1'b0; rx_empty[2] = 1'b1; tick();
  endtask

  task automatic t_tx_mode0();
    cfg = 32'h0001_0000;
    tx_full[0] = 1'b0; tick();
    check(irq_tx, 1'b1, "R4 not-full raises");
    pulse(0);
    check(irq_tx, 1'b1, "R9 data_rd keeps tx");
    pulse(1);
    check(irq_tx, 1'b0, "R9 data_wr clears tx");
    tx_full[0] = 1'b1; tick();
    check(irq_tx, 1'b0, "R4 full rising raises nothing");
  endtask

  task automatic t_tx_mode1();
    cfg = 32'h0808_0000;
    tx_full[3] = 1'b0; tick();
    check(irq_tx, 1'b0, "R5 not-full ignored in mode 1");
    tx_half[3] = 1'b0; tick();
    check(irq_tx, 1'b1, "R5 below half raises");
    pulse(2);
    check(irq_tx, 1'b0, "R9 ctrl_wr clears tx");
    tx_half[3] = 1'b1; tx_full[3] = 1'b1; tick();
  endtask

  task automatic t_enable();
    cfg = 32'h0001_0001;
    rx_empty[1] = 1'b0; tx_full[2] = 1'b0; tick();
    check(irq_rx, 1'b0, "R7 disabled rx link");
    check(irq_tx, 1'b0, "R7 disabled tx link");
    rx_empty[1] = 1'b1; tx_full[2] = 1'b1; tick();
  endtask

  task automatic t_module_off();
    cfg = 32'h0001_0001;
    rx_empty[0] = 1'b0; tx_full[0] = 1'b0; tick();
    check(irq_rx, 1'b1, "R10 setup rx");
    mod_en = 1'b0; tick();
    check(irq_rx, 1'b0, "R10 disable clears rx");
    check(irq_tx, 1'b0, "R10 disable clears tx");
    rx_empty[0] = 1'b1; tx_full[0] = 1'b1; tick();
    rx_empty[0] = 1'b0; tx_full[0] = 1'b0; tick();
    check(irq_rx, 1'b0, "R10 no rx pending while off");
    check(irq_tx, 1'b0, "R10 no tx pending while off");
    mod_en = 1'b1; tick();
    check(irq_rx, 1'b0, "R6 no rx after re-enable");
    rx_empty[0] = 1'b1; tx_full[0] = 1'b1; tick();
  endtask

  task automatic t_collision();
    cfg = 32'h0001_0001;
    rx_empty[0] = 1'b0; data_rd = 1'b1; tick();
    data_rd = 1'b0;
    check(irq_rx, 1'b1, "R11 rx trigger beats data_rd");
    tx_full[0] = 1'b0; ctrl_wr = 1'b1; tick();
    ctrl_wr = 1'b0;
    check(irq_tx, 1'b1, "R11 tx trigger beats ctrl_wr");
    check(irq_rx, 1'b0, "R8 ctrl_wr clears rx in collision");
    pulse(2);
    rx_empty[0] = 1'b1; tx_full[0] = 1'b1; tick();
  endtask

  task automatic t_depth1();
    d_cfg = 32'h0001_0001;
    d_en = 1'b1; tick();
    d_rx_empty[0] = 1'b0; tick();
    check(d_irq_rx, 1'b0, "R12 depth1 rx ignores not-empty");
    d_rx_half[0] = 1'b1; tick();
    check(d_irq_rx, 1'b1, "R12 depth1 rx half raises");
    d_tx_full[0] = 1'b0; tick();
    check(d_irq_tx, 1'b0, "R12 depth1 tx ignores not-full");
    d_tx_half[0] = 1'b0; tick();
    check(d_irq_tx, 1'b1, "R12 depth1 tx below half raises");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) tick();
    t_reset();
    rst_n = 1'b1;
    tick();
    t_reset();
    mod_en = 1'b1; tick();
    t_rx_mode0();
    t_rx_mode1();
    t_tx_mode0();
    t_tx_mode1();
    t_enable();
    t_module_off();
    t_collision();
    t_depth1();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule